// File: doc/BRIEF.md
# DMA channel run control

This block holds the run-control state for two DMA channels and decides, cycle by cycle, when each channel is enabled, armed, started, finished or aborted. The CPU reaches one 8-bit control register per channel over a small register bus. That bus takes either a full byte write or a write to one bit. A separate transfer engine moves the data. This block sends that engine a start strobe when a trigger is accepted and an abort strobe when software cancels a running transfer. The engine reports back with a done indication, and this block turns it into a one-cycle completion interrupt.

A channel accepts a trigger only when it is enabled, armed and not already running. The trigger comes either from its software trigger line or from one of sixteen hardware request lines, chosen by that channel's 4-bit source select. The enable bit is locked while the arm/status bit is set. A cancel therefore clears the status bit first and the enable bit in a later write. The enable bit also drives the channel's clock-enable output.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset, both control registers read 8'h00, and every clock-enable, start, abort and interrupt output is low.
- R2: Channel 0 sits at address 0 and channel 1 at address 1. Bit 7 is the enable flag and bit 0 is the arm/status flag. Bits 6 to 1 read as 0 and ignore writes.
- R3: A write that would change the enable flag has no effect while the status flag is 1. The enable flag takes the written value only when the status flag is 0. ch_en_o follows the enable flag.
- R4: With wr_bit_mode_i high, wr_bit_idx_i selects the bit to write and wr_data_i[0] carries its value. The other bit is left unchanged. An index from 1 to 6 changes nothing.
- R5: When a channel is enabled, armed and idle, a high software trigger or a high hardware request line at index src_sel_i[4c+3:4c] is accepted. This produces a single-cycle start_o pulse in the next cycle, and the channel becomes busy.
- R6: A trigger that arrives while the channel is disabled, not armed or busy is dropped and never queued. A trigger in the same cycle as a write that clears the status flag is also dropped.
- R7: done_i on a busy channel clears its status flag. In the first cycle the flag reads 0, irq_o is high for exactly one cycle. The enable flag is kept.
- R8: Writing 0 to the status flag of a busy channel makes abort_o pulse for one cycle in the next cycle and makes the channel idle, with no interrupt. This holds even if done_i is high in the same cycle, and a later done_i is ignored.
- R9: done_i on a channel that is not busy has no effect.
- R10: Each channel's hardware source select is independent. A request on any line other than the selected one does not start that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Channel register address |
| wr_bit_mode_i | input | 1 | 1: single-bit write, 0: byte write |
| wr_bit_idx_i | input | 3 | Bit index for a single-bit write |
| wr_data_i | input | 8 | Write data (bit 0 holds the value in bit mode) |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data of the addressed register |
| src_sel_i | input | 8 | Per-channel 4-bit hardware source select |
| hw_req_i | input | 16 | Hardware start request lines |
| sw_trig_i | input | 2 | Per-channel software trigger |
| done_i | input | 2 | Per-channel completion from the transfer engine |
| ch_en_o | output | 2 | Per-channel clock enable (enable flag) |
| start_o | output | 2 | Per-channel start strobe |
| abort_o | output | 2 | Per-channel abort strobe |
| irq_o | output | 2 | Per-channel completion interrupt |

## Verification
On every cycle, the assertions check these rules: the enable flag never moves while the status flag is set; a busy channel is always enabled and armed; a start pulse lasts one cycle and only happens on an armed channel; an interrupt or abort pulse comes with a cleared status flag; and an abort never comes with an interrupt. The bench scenarios are the only place that shows which trigger source and which select value start a channel. They also show that dropped triggers are not queued, that an abort beats a done in the same cycle, that single-bit writes leave the other bit alone, and that the read mux returns the right channel.

// File: rtl/dma_rc_pkg.sv
package dma_rc_pkg;
  localparam int CTRL_W = 8;
  localparam int IDX_W  = $clog2(CTRL_W);
  localparam int EN_BIT = 7;
  localparam int ST_BIT = 0;

  typedef struct packed {
    logic en;
    logic st;
  } ctrl_t;
endpackage

// File: rtl/dma_rc_src_mux.sv
module dma_rc_src_mux #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4
) (
  input  logic [NUM_SRC-1:0] hw_req_i,
  input  logic [SRC_W-1:0]   sel_i,
  output logic               trig_o
);
  always_comb begin
    trig_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SRC_W'(i)) trig_o = hw_req_i[i];
    end
  end
endmodule

// File: rtl/dma_rc_chan.sv
module dma_rc_chan
  import dma_rc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              bit_mode_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [CTRL_W-1:0] data_i,
  input  logic              sw_trig_i,
  input  logic              hw_trig_i,
  input  logic              done_i,
  output logic              en_o,
  output logic              st_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              irq_o
);
  ctrl_t ctrl_q;
  logic  busy_q;
  logic  start_q, abort_q, irq_q;

  logic touch_en, touch_st, val_en, val_st;
  logic st_clr_wr, trig_ok, finish;

  // byte mode: fields at their bit positions; bit mode: value in bit 0
  assign touch_en  = wr_i && (!bit_mode_i || bit_idx_i == IDX_W'(EN_BIT));
  assign touch_st  = wr_i && (!bit_mode_i || bit_idx_i == IDX_W'(ST_BIT));
  assign val_en    = bit_mode_i ? data_i[0] : data_i[EN_BIT];
  assign val_st    = data_i[ST_BIT];
  assign st_clr_wr = touch_st && !val_st;

  assign trig_ok = ctrl_q.en && ctrl_q.st && !busy_q &&
                   (sw_trig_i || hw_trig_i) && !st_clr_wr;
  assign finish  = done_i && busy_q && !st_clr_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (touch_en && !ctrl_q.st) ctrl_q.en <= val_en;
      if (st_clr_wr || finish)    ctrl_q.st <= 1'b0;
      else if (touch_st)          ctrl_q.st <= 1'b1;
      if (st_clr_wr || finish)    busy_q <= 1'b0;
      else if (trig_ok)           busy_q <= 1'b1;
      start_q <= trig_ok;
      abort_q <= st_clr_wr && busy_q;
      irq_q   <= finish;
    end
  end

  assign en_o    = ctrl_q.en;
  assign st_o    = ctrl_q.st;
  assign start_o = start_q;
  assign abort_o = abort_q;
  assign irq_o   = irq_q;

  assert_en_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.st |=> $stable(ctrl_q.en));
  assert_start_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (ctrl_q.st && busy_q));
  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_busy_armed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (ctrl_q.st && ctrl_q.en));
  assert_irq_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!ctrl_q.st && !busy_q));
  assert_abort_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!irq_o && !ctrl_q.st));
endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import dma_rc_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int SRC_W   = 4,
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic                    wr_bit_mode_i,
  input  logic [IDX_W-1:0]        wr_bit_idx_i,
  input  logic [CTRL_W-1:0]       wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [CTRL_W-1:0]       rd_data_o,
  input  logic [NUM_CH*SRC_W-1:0] src_sel_i,
  input  logic [NUM_SRC-1:0]      hw_req_i,
  input  logic [NUM_CH-1:0]       sw_trig_i,
  input  logic [NUM_CH-1:0]       done_i,
  output logic [NUM_CH-1:0]       ch_en_o,
  output logic [NUM_CH-1:0]       start_o,
  output logic [NUM_CH-1:0]       abort_o,
  output logic [NUM_CH-1:0]       irq_o
);
  logic [NUM_CH-1:0] en_w, st_w, hw_trig_w, wr_sel_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_sel_w[c] = wr_en_i && (wr_addr_i == ADDR_W'(c));

    dma_rc_src_mux #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_src (
      .hw_req_i (hw_req_i),
      .sel_i    (src_sel_i[c*SRC_W +: SRC_W]),
      .trig_o   (hw_trig_w[c])
    );

    dma_rc_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_sel_w[c]),
      .bit_mode_i (wr_bit_mode_i),
      .bit_idx_i  (wr_bit_idx_i),
      .data_i     (wr_data_i),
      .sw_trig_i  (sw_trig_i[c]),
      .hw_trig_i  (hw_trig_w[c]),
      .done_i     (done_i[c]),
      .en_o       (en_w[c]),
      .st_o       (st_w[c]),
      .start_o    (start_o[c]),
      .abort_o    (abort_o[c]),
      .irq_o      (irq_o[c])
    );
  end

  assign ch_en_o = en_w;

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr_i == ADDR_W'(i)) begin
        rd_data_o[EN_BIT] = en_w[i];
        rd_data_o[ST_BIT] = st_w[i];
      end
    end
  end

  assert_wr_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_w));
endmodule

// File: tb/dma_run_ctrl_tb.sv
module dma_run_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [0:0] wr_addr_i = '0;
  logic       wr_bit_mode_i = 1'b0;
  logic [2:0] wr_bit_idx_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [0:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [7:0] src_sel_i = '0;
  logic [15:0] hw_req_i = '0;
  logic [1:0] sw_trig_i = '0;
  logic [1:0] done_i = '0;
  logic [1:0] ch_en_o, start_o, abort_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [1:0] m_en = '0, m_st = '0, m_busy = '0;
  logic [1:0] e_start = '0, e_abort = '0, e_irq = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_run_ctrl u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_bit_mode_i, .wr_bit_idx_i,
    .wr_data_i, .rd_addr_i, .rd_data_o, .src_sel_i, .hw_req_i, .sw_trig_i,
    .done_i, .ch_en_o, .start_o, .abort_o, .irq_o
  );

  function automatic logic [7:0] exp_reg(input int c);
    return {m_en[c], 6'b0, m_st[c]};
  endfunction

  // reference model of one clock edge, from the requirements
  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      logic sel, t_en, t_st, v_en, clr, hw, trig, fin;
      sel  = wr_en_i && (wr_addr_i == 1'(c));
      t_en = sel && (!wr_bit_mode_i || wr_bit_idx_i == 3'd7);
      t_st = sel && (!wr_bit_mode_i || wr_bit_idx_i == 3'd0);
      v_en = wr_bit_mode_i ? wr_data_i[0] : wr_data_i[7];
      clr  = t_st && !wr_data_i[0];
      hw   = hw_req_i[src_sel_i[c*4 +: 4]];
      trig = m_en[c] && m_st[c] && !m_busy[c] && (sw_trig_i[c] || hw) && !clr;
      fin  = done_i[c] && m_busy[c] && !clr;
      e_start[c] = trig;
      e_abort[c] = clr && m_busy[c];
      e_irq[c]   = fin;
      if (t_en && !m_st[c]) m_en[c] = v_en;
      if (clr || fin) begin
        m_st[c] = 1'b0; m_busy[c] = 1'b0;
      end else begin
        if (t_st) m_st[c] = 1'b1;
        if (trig) m_busy[c] = 1'b1;
      end
    end
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, "/R2"}, "rd_data", rd_data_o, exp_reg(int'(rd_addr_i)));
    chk({tag, "/R3"}, "ch_en", {6'b0, ch_en_o}, {6'b0, m_en});
    chk({tag, "/R5"}, "start", {6'b0, start_o}, {6'b0, e_start});
    chk({tag, "/R8"}, "abort", {6'b0, abort_o}, {6'b0, e_abort});
    chk({tag, "/R7"}, "irq", {6'b0, irq_o}, {6'b0, e_irq});
  endtask

  task automatic idle_inputs();
    wr_en_i = 1'b0; wr_bit_mode_i = 1'b0; wr_bit_idx_i = '0; wr_data_i = '0;
    hw_req_i = '0; sw_trig_i = '0; done_i = '0;
  endtask

  // apply driven inputs for one edge, check at the following falling edge
  task automatic tick(input string tag);
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    check_all(tag);
    idle_inputs();
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d, input string tag);
    wr_en_i = 1'b1; wr_addr_i = a; wr_bit_mode_i = 1'b0; wr_data_i = d; rd_addr_i = a;
    tick(tag);
  endtask

  task automatic wr_bit(input logic a, input logic [2:0] idx, input logic v, input string tag);
    wr_en_i = 1'b1; wr_addr_i = a; wr_bit_mode_i = 1'b1; wr_bit_idx_i = idx;
    wr_data_i = {7'b0, v}; rd_addr_i = a;
    tick(tag);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    idle_inputs();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "rd0", rd_data_o, 8'h00);
    rd_addr_i = 1'b1; #1;
    chk("R1", "rd1", rd_data_o, 8'h00);
    chk("R1", "outs", {ch_en_o, start_o, abort_o, irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: byte write, unused bits read 0
    wr_byte(1'b0, 8'hFF, "R2");
    chk("R2", "ch0 after FF", rd_data_o, 8'h81);
    // R3: enable locked while armed
    wr_byte(1'b0, 8'h01, "R3");
    chk("R3", "en kept", rd_data_o, 8'h81);
    wr_byte(1'b0, 8'h00, "R3");
    chk("R3", "st cleared en kept", rd_data_o, 8'h80);
    wr_byte(1'b0, 8'h00, "R3");
    chk("R3", "en cleared", rd_data_o, 8'h00);
    // R4: bit writes
    wr_bit(1'b0, 3'd7, 1'b1, "R4");
    chk("R4", "bit7 set", rd_data_o, 8'h80);
    wr_bit(1'b0, 3'd3, 1'b1, "R4");
    chk("R4", "bit3 ignored", rd_data_o, 8'h80);
    wr_bit(1'b0, 3'd0, 1'b1, "R4");
    chk("R4", "bit0 set", rd_data_o, 8'h81);
    // R5: software start
    sw_trig_i = 2'b01; tick("R5");
    chk("R5", "start ch0", {6'b0, start_o}, 8'h01);
    // R6: trigger while busy dropped; R9: done on idle ch1 ignored
    sw_trig_i = 2'b01; done_i = 2'b10; tick("R6");
    chk("R6", "no restart", {6'b0, start_o}, 8'h00);
    chk("R9", "no irq ch1", {6'b0, irq_o}, 8'h00);
    // R7: completion
    done_i = 2'b01; tick("R7");
    chk("R7", "irq ch0", {6'b0, irq_o}, 8'h01);
    chk("R7", "st cleared", rd_data_o, 8'h80);
    tick("R7");
    chk("R7", "irq one cycle", {6'b0, irq_o}, 8'h00);
    // R8: abort beats done
    src_sel_i = 8'h52;
    wr_bit(1'b0, 3'd0, 1'b1, "R8");
    hw_req_i = 16'h0004; tick("R8");
    chk("R8", "hw start ch0", {6'b0, start_o}, 8'h01);
    wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'h80; done_i = 2'b01; tick("R8");
    chk("R8", "abort", {6'b0, abort_o}, 8'h01);
    chk("R8", "no irq", {6'b0, irq_o}, 8'h00);
    done_i = 2'b01; tick("R8");
    chk("R8", "late done ignored", {6'b0, irq_o}, 8'h00);
    // R6: disabled channel ignores trigger, not queued
    sw_trig_i = 2'b10; tick("R6");
    wr_byte(1'b1, 8'h81, "R6");
    tick("R6");
    chk("R6", "not queued", {6'b0, start_o}, 8'h00);
    // R10: independent select (ch1 uses line 5)
    hw_req_i = 16'h0004; tick("R10");
    chk("R10", "wrong line", {6'b0, start_o}, 8'h00);
    hw_req_i = 16'h0020; tick("R10");
    chk("R10", "selected line", {6'b0, start_o}, 8'h02);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        wr_en_i = 1'b1;
        wr_addr_i = 1'($urandom_range(0, 1));
        wr_bit_mode_i = 1'($urandom_range(0, 1));
        wr_bit_idx_i = ($urandom_range(0, 2) == 0) ? 3'($urandom) :
                       (($urandom_range(0, 1) == 0) ? 3'd0 : 3'd7);
        wr_data_i = 8'($urandom);
      end
      for (int b = 0; b < 16; b++) hw_req_i[b] = ($urandom_range(0, 15) == 0);
      sw_trig_i = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
      done_i = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
      if ($urandom_range(0, 63) == 0) src_sel_i = 8'($urandom);
      rd_addr_i = 1'($urandom_range(0, 1));
      tick("R5/R6/R7/R8/R9/R10");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule